// File: doc/BRIEF.md
# Parallel Display Bus Write Sequencer

The block turns a stream of host items into write cycles on an 8-bit parallel display bus of the 8080 style. The bus has an active-low select, an active-low write strobe, an active-low read strobe and a data-or-command line. A transaction opens with one command byte and continues with any number of parameter or pixel items, down to none. Each item is one byte or one 16-bit word. A word goes out as two strobed bytes, upper byte first. Select stays low across the whole transaction and is raised only once the final strobe has gone back high.

Items arrive over a valid/ready handshake. Each item carries a start-with-command flag, a width flag, a last-item flag and a 16-bit payload. The length of each strobe phase, in clock cycles, is set by two parameters. Every bus output is registered, so the bus pins change only on clock edges. The bus value stays fixed while the strobe is low and through its rising edge.

Top module: `pbus_write_seq`

## Requirements
- R1: During and after reset, `cs_n`, `wr_n`, `rd_n` and `is_data` are 1, `busy` is 0 and `in_ready` is 1.
- R2: An item accepted while idle with `in_first`=1 starts a transaction. On the next edge, `cs_n`, `is_data` and `wr_n` all drop to 0 and `bus_d` shows `in_payload[7:0]` as the command byte. `in_wide` is ignored for the command. `rd_n` stays 1 at all times.
- R3: Every byte gets exactly one strobe pulse. `wr_n` is low for exactly `STROBE_LO` cycles and then high for at least `STROBE_HI` cycles. `bus_d` does not change from the cycle `wr_n` falls through the cycle it rises.
- R4: Every byte that follows the command in the same transaction is strobed with `is_data`=1.
- R5: A data item with `in_wide`=0 sends `in_payload[7:0]` as a single byte.
- R6: A data item with `in_wide`=1 sends `in_payload[15:8]` and then `in_payload[7:0]`, each with its own strobe. The gap between the two strobes is exactly `STROBE_HI` cycles.
- R7: Bus line `bus_d[i]` carries bit i of the byte, so line 0 is the least significant bit.
- R8: `cs_n` stays low without a break from the command strobe to the end of the transaction. It rises exactly `STROBE_HI` cycles after the rising strobe of the byte from the item flagged `in_last`.
- R9: A command item with `in_last`=1 sends only the command byte and then releases `cs_n`.
- R10: `in_ready` is 1 only while idle or while waiting for the next data item, and `wr_n` is then high. An item accepted while idle with `in_first`=0 is dropped, with no strobe and no change on `cs_n`. Inside a transaction, `in_first` is ignored.
- R11: `busy` equals the inverse of `cs_n` in every cycle.
- R12: A reset during a transaction abandons it. All control outputs return high and `busy` drops, and the next transaction runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host item valid |
| in_ready | output | 1 | Block can take an item |
| in_first | input | 1 | Item is the command opening a transaction |
| in_wide | input | 1 | Data item is a 16-bit word (0: one byte) |
| in_last | input | 1 | Item is the last one of its transaction |
| in_payload | input | 16 | Command in bits 7:0, data byte in 7:0, or word |
| busy | output | 1 | Transaction in progress |
| cs_n | output | 1 | Bus select, active low |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, held high |
| is_data | output | 1 | 0: command byte, 1: data byte |
| bus_d | output | 8 | Parallel data lines |

## Verification
An item taken at clock edge k puts its byte on `bus_d` and pulls `wr_n` low at that same edge. The strobe rises at edge k+`STROBE_LO`. The lower half of a word falls `STROBE_HI` cycles after that rise. When the item is the last, `cs_n` rises at edge k+`STROBE_LO`+`STROBE_HI`. The bench samples every output on the falling clock edge. It measures these intervals by counting falling-edge samples between output transitions and compares the counts with the exact numbers above. The byte strobed in is taken from the sample just before the strobe rises, together with its data-or-command level, and compared against the byte order the requirements give.

// File: rtl/pbw_pkg.sv
package pbw_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOW   = 2'd1,
      ST_HIGH  = 2'd2,
      ST_FETCH = 2'd3
   } pbw_state_t;

   function automatic int unsigned pbw_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pbw_phase_timer.sv
module pbw_phase_timer #(
   parameter int unsigned STROBE_LO = 2,
   parameter int unsigned STROBE_HI = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic phase_hi,
   output logic expire
);
   localparam int unsigned MAXC = pbw_pkg::pbw_max(STROBE_LO, STROBE_HI);
   localparam int unsigned CW   = $clog2(MAXC + 1);

   if (STROBE_LO < 1) begin : g_bad_lo
      $error("STROBE_LO must be at least 1");
   end
   if (STROBE_HI < 1) begin : g_bad_hi
      $error("STROBE_HI must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else          cnt <= cnt + 1'b1;
   end

   if (STROBE_LO == STROBE_HI) begin : g_same
      logic unused_phase;
      assign unused_phase = phase_hi;
      assign expire = (cnt == CW'(STROBE_LO - 1));
   end else begin : g_split
      assign expire = phase_hi ? (cnt == CW'(STROBE_HI - 1))
                               : (cnt == CW'(STROBE_LO - 1));
   end

   // the counter never runs past the longer phase
   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(MAXC));

endmodule

// File: rtl/pbw_byte_lane.sv
module pbw_byte_lane #(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_first,
   input  logic          ld_second,
   input  logic          item_wide,
   input  logic [2*DW-1:0] item_data,
   output logic [DW-1:0] bus_q
);
   if (DW < 1) begin : g_bad_dw
      $error("DW must be at least 1");
   end

   logic [DW-1:0] spare;
   logic [DW-1:0] lane_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane_q <= '0;
         spare  <= '0;
      end else if (ld_first) begin
         lane_q <= item_wide ? item_data[2*DW-1:DW] : item_data[DW-1:0];
         spare  <= item_data[DW-1:0];
      end else if (ld_second) begin
         lane_q <= spare;
      end
   end

   // one output line per bit, line i carries bit i
   for (genvar i = 0; i < int'(DW); i++) begin : g_line
      assign bus_q[i] = lane_q[i];
   end

   a_r6_one_load: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_first && ld_second));

endmodule

// File: rtl/pbus_write_seq.sv
module pbus_write_seq #(
   parameter int unsigned DW        = 8,
   parameter int unsigned STROBE_LO = 2,
   parameter int unsigned STROBE_HI = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic          in_first,
   input  logic          in_wide,
   input  logic          in_last,
   input  logic [2*DW-1:0] in_payload,
   output logic          busy,
   output logic          cs_n,
   output logic          wr_n,
   output logic          rd_n,
   output logic          is_data,
   output logic [DW-1:0] bus_d
);
   import pbw_pkg::*;

   pbw_state_t state;
   logic cs_q, wr_q, dat_q, half_pend, last_seen;
   logic accept, expire, t_clr, ld_first, ld_second;

   assign in_ready = (state == ST_IDLE) || (state == ST_FETCH);
   assign accept   = in_valid && in_ready;
   assign busy     = (state != ST_IDLE);

   assign ld_first  = accept && ((state == ST_FETCH) || in_first);
   assign ld_second = (state == ST_HIGH) && expire && half_pend;
   assign t_clr     = !(((state == ST_LOW) || (state == ST_HIGH)) && !expire);

   pbw_phase_timer #(.STROBE_LO(STROBE_LO), .STROBE_HI(STROBE_HI)) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (t_clr),
      .phase_hi (state == ST_HIGH),
      .expire   (expire)
   );

   pbw_byte_lane #(.DW(DW)) lane_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_first  (ld_first),
      .ld_second (ld_second),
      .item_wide ((state == ST_FETCH) && in_wide),
      .item_data (in_payload),
      .bus_q     (bus_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cs_q      <= 1'b1;
         wr_q      <= 1'b1;
         dat_q     <= 1'b1;
         half_pend <= 1'b0;
         last_seen <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (accept && in_first) begin
               state     <= ST_LOW;
               cs_q      <= 1'b0;
               dat_q     <= 1'b0;
               wr_q      <= 1'b0;
               half_pend <= 1'b0;
               last_seen <= in_last;
            end
            ST_LOW: if (expire) begin
               wr_q  <= 1'b1;
               state <= ST_HIGH;
            end
            ST_HIGH: if (expire) begin
               if (half_pend) begin
                  half_pend <= 1'b0;
                  wr_q      <= 1'b0;
                  state     <= ST_LOW;
               end else if (last_seen) begin
                  cs_q  <= 1'b1;
                  state <= ST_IDLE;
               end else begin
                  state <= ST_FETCH;
               end
            end
            ST_FETCH: if (accept) begin
               state     <= ST_LOW;
               wr_q      <= 1'b0;
               dat_q     <= 1'b1;
               half_pend <= in_wide;
               last_seen <= in_last;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cs_n    = cs_q;
   assign wr_n    = wr_q;
   assign is_data = dat_q;
   assign rd_n    = 1'b1;

   a_r11_busy_cs: assert property (@(posedge clk) disable iff (!rst_n)
      busy == !cs_n);
   a_r3_bus_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n && $past(!wr_n)) |-> $stable(bus_d));
   a_r3_bus_hold_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_n) |-> $stable(bus_d));
   a_r2_cmd_open: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> (!is_data && !wr_n));
   a_r4_data_level: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(wr_n) && !$fell(cs_n)) |-> is_data);
   a_r8_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (wr_n && $past(wr_n)));
   a_r10_ready_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> wr_n);

endmodule

// File: tb/pbus_write_seq_tb_top.sv
module pbus_write_seq_tb_top;
   localparam int LO = 2;
   localparam int HI = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_first = 1'b0, in_wide = 1'b0, in_last = 1'b0;
   logic [15:0] in_payload = '0;
   logic in_ready, busy, cs_n, wr_n, rd_n, is_data;
   logic [7:0] bus_d;

   always #2 clk = ~clk;

   pbus_write_seq #(.DW(8), .STROBE_LO(LO), .STROBE_HI(HI)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_first(in_first), .in_wide(in_wide), .in_last(in_last),
      .in_payload(in_payload), .busy(busy), .cs_n(cs_n), .wr_n(wr_n),
      .rd_n(rd_n), .is_data(is_data), .bus_d(bus_d)
   );

   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // bus monitor on the falling edge
   logic pw = 1'b1, pc = 1'b1, pdc = 1'b1;
   logic [7:0] pb = '0;
   int lo_len = 0, hi_len = 0, cs_falls = 0, wr_falls = 0, cap_n = 0;
   logic [7:0] cap_b [0:31];
   logic       cap_dc[0:31];

   always @(negedge clk) begin
      if (!rst_n) begin
         pw = 1'b1; pc = 1'b1; pdc = 1'b1; lo_len = 0; hi_len = 0;
      end else begin
         if (pw && !wr_n) begin
            wr_falls++;
            if (!pc) chk(hi_len >= HI, "R3 high phase length", hi_len, HI);
            lo_len = 0;
         end
         if (!wr_n) begin
            lo_len++;
            if (!pw) chk(bus_d == pb, "R3 bus stable while low", bus_d, pb);
         end
         if (!pw && wr_n) begin
            chk(lo_len == LO, "R3 low phase length", lo_len, LO);
            chk(bus_d == pb, "R3 bus stable at rise", bus_d, pb);
            chk(rd_n == 1'b1, "R2 read strobe high", rd_n, 1);
            chk(pc == 1'b0, "R8 select low during strobe", pc, 0);
            if (cap_n < 32) begin
               cap_b[cap_n] = pb; cap_dc[cap_n] = pdc; cap_n++;
            end
            hi_len = 0;
         end
         if (wr_n && !cs_n) hi_len++;
         if (!pc && cs_n) chk(hi_len == HI, "R8 release delay", hi_len, HI);
         if (pc && !cs_n) cs_falls++;
         pw = wr_n; pc = cs_n; pdc = is_data; pb = bus_d;
      end
   end

   logic [7:0] exp_b [0:31];
   logic       exp_dc[0:31];
   int exp_n = 0;

   task automatic begin_tx();
      exp_n = 0; cap_n = 0; cs_falls = 0;
   endtask

   task automatic want(input logic [7:0] b, input logic d);
      exp_b[exp_n] = b; exp_dc[exp_n] = d; exp_n++;
   endtask

   task automatic send(input logic f, input logic w, input logic l, input logic [15:0] p);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_first = f; in_wide = w; in_last = l; in_payload = p;
      @(negedge clk);
      in_valid = 1'b0; in_first = 1'b0; in_wide = 1'b0; in_last = 1'b0;
   endtask

   task automatic end_tx(input string req);
      int guard = 0;
      while (busy && guard < 500) begin @(negedge clk); guard++; end
      repeat (2) @(negedge clk);
      chk(cap_n == exp_n, {req, " byte count"}, cap_n, exp_n);
      for (int i = 0; i < exp_n && i < cap_n; i++) begin
         chk(cap_b[i] == exp_b[i], {req, " byte value"}, cap_b[i], exp_b[i]);
         chk(cap_dc[i] == exp_dc[i], {req, " data/command level"}, cap_dc[i], exp_dc[i]);
      end
      chk(cs_falls == 1, "R8 one select window", cs_falls, 1);
      chk(cs_n == 1'b1 && busy == 1'b0, "R11 idle after transaction", {cs_n, busy}, 2'b10);
   endtask

   task automatic t_reset();
      chk({cs_n, wr_n, rd_n, is_data} == 4'hF, "R1 control idle", {cs_n, wr_n, rd_n, is_data}, 4'hF);
      chk(busy == 1'b0 && in_ready == 1'b1, "R1 busy/ready", {busy, in_ready}, 2'b01);
   endtask

   task automatic t_cmd_only();
      begin_tx();
      want(8'hC3, 1'b0);
      send(1'b1, 1'b1, 1'b1, 16'h77C3);   // R9, wide flag ignored on command
      chk(busy == 1'b1 && cs_n == 1'b0, "R11 busy with select", {busy, cs_n}, 2'b10);
      end_tx("R9 command only");
   endtask

   task automatic t_bytes();
      begin_tx();
      want(8'h2A, 1'b0); want(8'h01, 1'b1); want(8'h80, 1'b1);
      want(8'hFF, 1'b1); want(8'h00, 1'b1);
      send(1'b1, 1'b0, 1'b0, 16'h002A);
      send(1'b0, 1'b0, 1'b0, 16'hEE01);   // R5 upper half unused, R7 single bit lines
      send(1'b0, 1'b0, 1'b0, 16'h0080);
      send(1'b0, 1'b0, 1'b0, 16'h00FF);
      send(1'b0, 1'b0, 1'b1, 16'h5500);
      end_tx("R5 R4 R7 byte items");
   endtask

   task automatic t_words();
      begin_tx();
      want(8'h2C, 1'b0); want(8'h12, 1'b1); want(8'h34, 1'b1);
      want(8'hAB, 1'b1); want(8'hCD, 1'b1);
      send(1'b1, 1'b0, 1'b0, 16'h002C);
      send(1'b0, 1'b1, 1'b0, 16'h1234);
      send(1'b0, 1'b1, 1'b1, 16'hABCD);
      end_tx("R6 word items");
   endtask

   task automatic t_mixed();
      begin_tx();
      want(8'h3C, 1'b0); want(8'h55, 1'b1); want(8'hF0, 1'b1);
      want(8'h0F, 1'b1); want(8'hAA, 1'b1);
      send(1'b1, 1'b0, 1'b0, 16'h003C);
      send(1'b1, 1'b0, 1'b0, 16'h0055);   // R10 start flag ignored mid-transaction
      send(1'b0, 1'b1, 1'b0, 16'hF00F);
      send(1'b0, 1'b0, 1'b1, 16'h00AA);
      end_tx("R10 R6 mixed items");
   endtask

   task automatic t_stray();
      int wf;
      wf = wr_falls;
      begin_tx();
      send(1'b0, 1'b0, 1'b0, 16'h0099);
      repeat (10) @(negedge clk);
      chk(cs_falls == 0, "R10 stray item select", cs_falls, 0);
      chk(wr_falls == wf, "R10 stray item strobe", wr_falls, wf);
      chk(busy == 1'b0 && in_ready == 1'b1, "R10 stray item idle", {busy, in_ready}, 2'b01);
   endtask

   task automatic t_midreset();
      begin_tx();
      send(1'b1, 1'b0, 1'b0, 16'h0011);
      send(1'b0, 1'b1, 1'b0, 16'h2233);
      repeat (1) @(negedge clk);
      chk(cs_n == 1'b0, "R12 transaction open", cs_n, 0);
      rst_n = 1'b0;
      @(negedge clk);
      chk({cs_n, wr_n, rd_n, is_data} == 4'hF, "R12 control idle", {cs_n, wr_n, rd_n, is_data}, 4'hF);
      chk(busy == 1'b0, "R12 busy dropped", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      begin_tx();
      want(8'h5D, 1'b0); want(8'h7E, 1'b1);
      send(1'b1, 1'b0, 1'b0, 16'h005D);
      send(1'b0, 1'b0, 1'b1, 16'h007E);
      end_tx("R12 after reset");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cmd_only();
      t_bytes();
      t_words();
      t_mixed();
      t_stray();
      t_midreset();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule